// File: doc/BRIEF.md
# Two-Digit Decimal Up/Down Counter

This block keeps a fixed-point decimal value between 0.0 and 9.9 as a pair of BCD digits: a ones digit and a tenths digit. The value moves by one tenth on each slow tick enable. A direction input chooses whether it counts up or down. The two digits leave the block directly and feed a seven-segment decoder that lives elsewhere.

Each direction has its own starting value. Counting up starts at 0.0 and counting down starts at 9.9. The counter loads that start value in three cases: on reset, when the direction input changes, and when the count runs past the end of its range. Up counting steps from 9.9 to 0.0, and down counting steps from 0.0 to 9.9. The direction bit is the low bit of the demo selector, so selector 0000 gives up counting and 0001 gives down counting.

Top module: `bcd_updown_counter`

## Requirements
- R1: When `rst_i` is high at a rising clock edge, that edge loads the start value for the current `dir_i`: 0.0 if `dir_i`=0 and 9.9 if `dir_i`=1. Reset wins over `tick_i`.
- R2: `ones_o` holds the ones digit and `tenths_o` holds the tenths digit. Both are plain BCD and never exceed 9.
- R3: If `tick_i` is low and `dir_i` has not changed, the value holds.
- R4: In up counting (`dir_i`=0), a tick adds one to the tenths digit. A tenths digit of 9 becomes 0 and carries one into the ones digit.
- R5: In down counting (`dir_i`=1), a tick subtracts one from the tenths digit. A tenths digit of 0 becomes 9 and borrows one from the ones digit.
- R6: In up counting, a tick at 9.9 loads 0.0.
- R7: In down counting, a tick at 0.0 loads 9.9.
- R8: If `dir_i` differs from its value at the previous edge, the new direction's start value is loaded at this edge. This takes priority over a tick.
- R9: Outputs are registered. A tick sampled at an edge shows on the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Slow step enable, one clock wide per step |
| dir_i | input | 1 | 0 = count up, 1 = count down |
| ones_o | output | 4 | Ones digit, BCD |
| tenths_o | output | 4 | Tenths digit, BCD |

## Verification
A bad internal state reaches the ports on the very next edge. A digit that skips or repeats a value shows up on the first tick after it. A wrong carry or borrow shows up as a mismatch in the ones digit when the tenths digit crosses its boundary. A lost or stale direction register shows up as a missing reload, or an extra one, on the edge after `dir_i` toggles. The bench compares both digits against its model after every clock edge, so the fault is found within one cycle of when it first becomes visible.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int DIGW = 4;
  localparam int NDIG = 2;
  localparam logic [DIGW-1:0] DMAX = DIGW'(9);
  localparam logic [DIGW-1:0] DMIN = '0;

  typedef logic [DIGW-1:0] digit_t;

  // up: next digit counting up (1) or down (0), wrapping within 0..9
  function automatic digit_t bcd_next(digit_t d, logic up);
    if (up) return (d == DMAX) ? DMIN : d + DIGW'(1);
    else    return (d == DMIN) ? DMAX : d - DIGW'(1);
  endfunction

  // digit sits at the edge where a step produces a carry or borrow
  function automatic logic bcd_at_edge(digit_t d, logic up);
    return up ? (d == DMAX) : (d == DMIN);
  endfunction

  function automatic digit_t bcd_start(logic up);
    return up ? DMIN : DMAX;
  endfunction
endpackage

// File: rtl/bcd_dir_watch.sv
module bcd_dir_watch (
  input  logic clk_i,
  input  logic rst_i,
  input  logic dir_i,
  output logic dir_chg_o
);
  logic dir_q;

  always_ff @(posedge clk_i) dir_q <= dir_i;

  assign dir_chg_o = ~rst_i & (dir_i ^ dir_q);

  // R8: a reported change means the input differs from last edge's value
  p_chg_tracks_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    dir_chg_o |-> (dir_i != $past(dir_i)));
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
  import bcd_cnt_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   load_i,
  input  logic   up_i,
  input  logic   step_i,
  output digit_t digit_o,
  output logic   step_o
);
  digit_t d_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || load_i) d_q <= bcd_start(up_i);
    else if (step_i)     d_q <= bcd_next(d_q, up_i);
  end

  assign digit_o = d_q;
  assign step_o  = step_i & bcd_at_edge(d_q, up_i);

  // R2: digit stays decimal
  p_digit_legal_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    digit_o <= DMAX);
  // R4 / R5: a carry or borrow leaves the digit at its opposite bound
  p_carry_wraps_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_o && !load_i) |=> (digit_o == bcd_start($past(up_i))));
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_cnt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            tick_i,
  input  logic            dir_i,
  output logic [DIGW-1:0] ones_o,
  output logic [DIGW-1:0] tenths_o
);
  logic            dir_chg;
  logic            up;
  logic [NDIG:0]   step;
  digit_t          dig [NDIG];
  logic [2*DIGW-1:0] value;

  assign up      = ~dir_i;
  assign step[0] = tick_i & ~dir_chg;

  bcd_dir_watch u_dir (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .dir_i    (dir_i),
    .dir_chg_o(dir_chg)
  );

  // digit 0 = tenths, digit 1 = ones; carry/borrow ripples upward
  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    bcd_digit u_d (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (dir_chg),
      .up_i   (up),
      .step_i (step[i]),
      .digit_o(dig[i]),
      .step_o (step[i+1])
    );
  end

  assign tenths_o = dig[0];
  assign ones_o   = dig[1];
  assign value    = {ones_o, tenths_o};

  // R3: no tick and no direction change -> hold
  p_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tick_i && !dir_chg) |=> $stable(value));
  // R8: direction change reloads the new start value
  p_dir_reload_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    dir_chg |=> (value == ($past(dir_i) ? 8'h99 : 8'h00)));
  // R6: up wrap
  p_up_wrap_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && !dir_chg && !dir_i && value == 8'h99) |=> (value == 8'h00));
  // R7: down wrap
  p_down_wrap_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && !dir_chg && dir_i && value == 8'h00) |=> (value == 8'h99));
endmodule

// File: tb/tb_bcd_updown_counter.sv
module tb_bcd_updown_counter;
  logic clk = 1'b0;
  logic rst, tick, dir;
  logic [3:0] ones, tenths;
  int checks = 0;
  int errors = 0;
  int mv = 0;      // model value 0..99 (tenths units)
  logic pdir = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bcd_updown_counter dut (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .dir_i(dir),
    .ones_o(ones), .tenths_o(tenths)
  );

  function automatic int model_next(int v, bit r, bit t, bit d, bit pd);
    if (r)       return d ? 99 : 0;
    if (d != pd) return d ? 99 : 0;
    if (!t)      return v;
    if (!d)      return (v == 99) ? 0 : v + 1;
    return (v == 0) ? 99 : v - 1;
  endfunction

  function automatic string tag_of(int v, bit r, bit t, bit d, bit pd);
    if (r)       return "R1";
    if (d != pd) return "R8";
    if (!t)      return "R3";
    if (!d)      return (v == 99) ? "R6" : ((v % 10 == 9) ? "R4 carry R9" : "R4 R9");
    return (v == 0) ? "R7" : ((v % 10 == 0) ? "R5 borrow R9" : "R5 R9");
  endfunction

  // called at negedge: drive, cross one posedge, compare at next negedge
  task automatic step(bit r, bit t, bit d);
    string tg;
    rst = r; tick = t; dir = d;
    @(posedge clk);
    tg = tag_of(mv, r, t, d, pdir);
    mv = model_next(mv, r, t, d, pdir);
    pdir = d;
    @(negedge clk);
    checks++;
    if (ones !== 4'(mv / 10) || tenths !== 4'(mv % 10)) begin
      errors++;
      $display("FAIL %s: got %0d.%0d expected %0d.%0d", tg, ones, tenths, mv / 10, mv % 10);
    end
    checks++;
    if (ones > 4'd9 || tenths > 4'd9) begin
      errors++;
      $display("FAIL R2: got digits %0d.%0d expected both <= 9", ones, tenths);
    end
  endtask

  initial begin
    rst = 1'b1; tick = 1'b0; dir = 1'b0;
    @(negedge clk);
    step(1, 0, 0);                 // R1 reset up -> 0.0
    step(1, 1, 1);                 // R1 reset down with tick -> 9.9
    step(0, 0, 1);                 // R3 hold
    step(0, 1, 1);                 // R5 9.9 -> 9.8
    for (int i = 0; i < 8; i++) step(0, 1, 1);
    step(0, 1, 1);                 // R5 borrow 9.0 -> 8.9
    step(0, 1, 0);                 // R8 change beats tick -> 0.0
    for (int i = 0; i < 10; i++) step(0, 1, 0);  // R4 carry to 1.0
    for (int i = 0; i < 89; i++) step(0, 1, 0);  // reach 9.9
    step(0, 1, 0);                 // R6 wrap -> 0.0
    step(0, 0, 1);                 // R8 -> 9.9
    for (int i = 0; i < 99; i++) step(0, 1, 1);  // reach 0.0
    step(0, 1, 1);                 // R7 wrap -> 9.9
    step(0, 0, 1);                 // R3 hold
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      bit r, t, d;
      r = ($urandom % 200) == 0;
      t = ($urandom % 2) == 0;
      d = (($urandom % 60) == 0) ? ~dir : dir;
      step(r, t, d);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule